// File: doc/BRIEF.md
# Voice Sample Cache Controller

This block keeps a 64-frame ring cache for one audio voice. A sample consumer takes frames at the read pointer. A memory fetch engine refills the empty part of the ring in fixed 32-byte bursts. The controller tracks three values:

- the current fetch address, which counts in frames;
- the ring read pointer;
- the number of empty slots, called the invalid count.

When it is time to refill, the controller raises a request. The request carries a start address and a length. The engine grants the request and then returns frames one per `fill_valid_i` strobe. The controller writes each returned frame into the next empty slot.

A consume moves the read pointer, the current address and the invalid count forward together. For this reason the audible frame always trails the current address by 64 frames.

When a consume brings the current address to the loop end, these things happen:
- the current address reloads to the loop start;
- a one-cycle loop flag is raised;
- the loop-end address is latched, and so is the count of empty slots not yet requested.

The next refills then take exactly that many frames from just before the loop end. After that, the linear fetch resumes from the loop start. This way, frames that still belong before the loop point are not fetched from the wrong place.

The refill path is a three-state machine:
- `ST_IDLE`: no request is open. It moves to `ST_REQ` once the unrequested empty slots reach the burst size.
- `ST_REQ`: the request is held. It moves to `ST_FILL` on a grant.
- `ST_FILL`: frames are being received. It returns to `ST_IDLE` when the last frame of the burst is written.

Top module: `vsc_cache_ctrl`

## Requirements
- R1: After a synchronous reset the invalid count is 64, the current address is 0, no fetch request is raised, the loop flag is low and `frame_ok_o` is low.
- R2: A consume while the invalid count is below 64 advances the read pointer and the current address by one and raises the invalid count by one. A consume while the invalid count is 64 changes nothing.
- R3: `fmt_i` bit 1 selects 16-bit samples and bit 0 selects stereo. The burst size in frames is 32 bytes divided by the frame size: 32 for 8-bit mono, 16 for 8-bit stereo and for 16-bit mono, and 8 for 16-bit stereo. A request is raised only while the unrequested empty slots (invalid count minus frames still owed) are at least the burst size. Without a loop redirect, the granted length equals the burst size.
- R4: Without a redirect, the request address is the current address minus the unrequested empty count. Returned frames land in slots starting at the read pointer minus that count.
- R5: Each `fill_valid_i` during an open burst writes one frame and lowers the invalid count by one. `fill_valid_i` outside a burst has no effect.
- R6: A raised request stays high until granted. Each grant opens exactly one burst.
- R7: A consume that makes the current address equal the loop end reloads the current address to the loop start. The loop flag is high for exactly the following cycle.
- R8: At a loop crossing, the unrequested empty count after that cycle becomes the redirect count. While the redirect count is nonzero:
  - each request is for the smaller of the burst size and the redirect count;
  - the address is the loop end minus the redirect count;
  - each grant lowers the redirect count by the granted length.
- R9: `frame_ok_o` is high exactly when the invalid count is below 64. `frame_o` is then the frame stored for the memory address that was current 64 consumes earlier, with loop reloads followed.
- R10: The invalid count never exceeds 64. A consume and a fill write in the same cycle leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fmt_i | input | 2 | Bit 1: 16-bit samples; bit 0: stereo |
| loop_start_i | input | ADDR_W | Frame address the current address reloads to |
| loop_end_i | input | ADDR_W | Frame address that triggers a loop crossing |
| consume_i | input | 1 | Take the frame at the read pointer |
| frame_o | output | FRAME_W | Frame stored at the read pointer |
| frame_ok_o | output | 1 | Read-pointer slot holds a valid frame |
| cur_addr_o | output | ADDR_W | Current fetch address in frames |
| inv_cnt_o | output | 7 | Number of empty slots (0..64) |
| loop_flag_o | output | 1 | One-cycle pulse after a loop crossing |
| fetch_req_o | output | 1 | Refill request |
| fetch_addr_o | output | ADDR_W | First frame address of the requested burst |
| fetch_len_o | output | 7 | Frames in the requested burst |
| fetch_gnt_i | input | 1 | Fetch engine accepts the request |
| fill_valid_i | input | 1 | One returned frame is on `fill_data_i` |
| fill_data_i | input | FRAME_W | Returned frame |

## Verification
Two pairs of events can fall in the same clock cycle:
- A consume and a fill write, which raise and lower the invalid count at once.
- A loop crossing and a grant. Here the granted burst must keep its pre-crossing linear address, and the redirect count must leave out the frames just granted.

Both pairs are provoked by running consume, grant and fill strobes from a seeded random source at high rates over several loop periods. This is done in every format.

Both are judged in two ways. First, a bench model tracks the invalid count, the frames owed and the redirect count, and each grant's address and length are compared against it. Second, every consumed frame is compared with the memory word at the address that was current 64 consumes earlier. A misplaced or misrouted refill therefore shows up as a wrong frame.

// File: rtl/vsc_pkg.sv
package vsc_pkg;

    // Format select encoding: bit 1 = 16-bit samples, bit 0 = stereo
    typedef enum logic [1:0] {
        FMT_8_MONO    = 2'b00,
        FMT_8_STEREO  = 2'b01,
        FMT_16_MONO   = 2'b10,
        FMT_16_STEREO = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_FILL = 2'd2
    } refill_st_e;

    // Frames per fetch burst: burst bytes divided by bytes per frame
    function automatic int unsigned burst_frames(input logic [1:0] fmt,
                                                 input int unsigned fetch_bytes);
        return fetch_bytes >> (int'(fmt[1]) + int'(fmt[0]));
    endfunction

endpackage

// File: rtl/vsc_frame_store.sv
module vsc_frame_store #(
    parameter int FRAME_W = 32,
    parameter int DEPTH   = 64,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               we_i,
    input  logic [IDX_W-1:0]   waddr_i,
    input  logic [FRAME_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]   raddr_i,
    output logic [FRAME_W-1:0] rdata_o
);

    // One slot per frame in every format; 8-bit frames use the low half
    logic [FRAME_W-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            slots[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = slots[raddr_i];

endmodule

// File: rtl/vsc_pointers.sv
module vsc_pointers #(
    parameter int ADDR_W = 24,
    parameter int DEPTH  = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              consume_i,
    input  logic              fill_we_i,
    input  logic [ADDR_W-1:0] loop_start_i,
    input  logic [ADDR_W-1:0] loop_end_i,
    output logic [IDX_W-1:0]  rd_ptr_o,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic [CNT_W-1:0]  inv_cnt_o,
    output logic [CNT_W-1:0]  inv_nxt_o,
    output logic              consume_ok_o,
    output logic              loop_hit_o
);

    localparam logic [CNT_W-1:0] FULL_EMPTY = CNT_W'(DEPTH);

    logic [IDX_W-1:0]  rd_ptr_q;
    logic [ADDR_W-1:0] cur_addr_q;
    logic [CNT_W-1:0]  inv_q;

    // A consume is only taken when the read slot holds data
    assign consume_ok_o = consume_i && (inv_q != FULL_EMPTY);
    assign loop_hit_o   = consume_ok_o && ((cur_addr_q + ADDR_W'(1)) == loop_end_i);

    always_comb begin
        inv_nxt_o = inv_q;
        if (consume_ok_o && !fill_we_i) begin
            inv_nxt_o = inv_q + CNT_W'(1);
        end else if (!consume_ok_o && fill_we_i) begin
            inv_nxt_o = inv_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr_q   <= '0;
            cur_addr_q <= '0;
            inv_q      <= FULL_EMPTY;
        end else begin
            inv_q <= inv_nxt_o;
            if (consume_ok_o) begin
                rd_ptr_q <= rd_ptr_q + IDX_W'(1);
                if (loop_hit_o) begin
                    cur_addr_q <= loop_start_i;
                end else begin
                    cur_addr_q <= cur_addr_q + ADDR_W'(1);
                end
            end
        end
    end

    assign rd_ptr_o   = rd_ptr_q;
    assign cur_addr_o = cur_addr_q;
    assign inv_cnt_o  = inv_q;

    // R10: the empty count stays within the ring size
    p_inv_bound_r10: assert property (@(posedge clk) disable iff (rst)
        inv_q <= FULL_EMPTY);

    // R10: simultaneous consume and fill cancel out
    p_consume_fill_r10: assert property (@(posedge clk) disable iff (rst)
        consume_ok_o && fill_we_i |=> $stable(inv_q));

    // R2: consume on an empty ring moves nothing
    p_empty_ignore_r2: assert property (@(posedge clk) disable iff (rst)
        consume_i && (inv_q == FULL_EMPTY) && !fill_we_i
        |=> $stable(rd_ptr_q) && $stable(cur_addr_q) && $stable(inv_q));

    // R7: reaching the loop end reloads the loop start
    p_reload_r7: assert property (@(posedge clk) disable iff (rst)
        loop_hit_o |=> cur_addr_q == $past(loop_start_i));

endmodule

// File: rtl/vsc_refill_fsm.sv
module vsc_refill_fsm #(
    parameter int DEPTH  = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] thr_i,
    input  logic [CNT_W-1:0] unreq_i,
    input  logic [CNT_W-1:0] redir_i,
    input  logic [IDX_W-1:0] rd_ptr_i,
    input  logic             gnt_i,
    input  logic             fill_valid_i,
    output logic             req_o,
    output logic             grant_o,
    output logic [CNT_W-1:0] len_o,
    output logic [CNT_W-1:0] pend_o,
    output logic [CNT_W-1:0] pend_nxt_o,
    output logic             we_o,
    output logic [IDX_W-1:0] waddr_o
);
    import vsc_pkg::*;

    refill_st_e       st_q, st_d;
    logic [CNT_W-1:0] pend_q;
    logic [IDX_W-1:0] wp_q;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (unreq_i >= thr_i) st_d = ST_REQ;
            ST_REQ:  if (gnt_i) st_d = ST_FILL;
            ST_FILL: if (fill_valid_i && (pend_q == CNT_W'(1))) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_o   = (st_q == ST_REQ);
        grant_o = (st_q == ST_REQ) && gnt_i;
        we_o    = (st_q == ST_FILL) && fill_valid_i;
        if ((redir_i != '0) && (redir_i < thr_i)) begin
            len_o = redir_i;
        end else begin
            len_o = thr_i;
        end
        if (grant_o) begin
            pend_nxt_o = len_o;
        end else if (we_o) begin
            pend_nxt_o = pend_q - CNT_W'(1);
        end else begin
            pend_nxt_o = pend_q;
        end
    end

    // Burst bookkeeping: owed frames and next destination slot
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            wp_q   <= '0;
        end else begin
            pend_q <= pend_nxt_o;
            if (grant_o) begin
                wp_q <= rd_ptr_i - unreq_i[IDX_W-1:0];
            end else if (we_o) begin
                wp_q <= wp_q + IDX_W'(1);
            end
        end
    end

    assign pend_o  = pend_q;
    assign waddr_o = wp_q;

    // R6: a request is held until the engine grants it
    p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
        req_o && !gnt_i |=> req_o);

    // R3: requests only with room for a whole burst, nonzero length
    p_req_room_r3: assert property (@(posedge clk) disable iff (rst)
        req_o |-> (unreq_i >= thr_i) && (len_o != '0) && (len_o <= thr_i));

    // R5: writes only happen while frames are owed
    p_fill_owed_r5: assert property (@(posedge clk) disable iff (rst)
        we_o |-> pend_q != '0);

endmodule

// File: rtl/vsc_loop_tracker.sv
module vsc_loop_tracker #(
    parameter int ADDR_W = 24,
    parameter int DEPTH  = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              loop_hit_i,
    input  logic [ADDR_W-1:0] loop_end_i,
    input  logic [ADDR_W-1:0] cur_addr_i,
    input  logic [CNT_W-1:0]  unreq_i,
    input  logic [CNT_W-1:0]  unreq_nxt_i,
    input  logic              grant_i,
    input  logic [CNT_W-1:0]  len_i,
    output logic [CNT_W-1:0]  redir_o,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic              loop_flag_o
);

    logic [ADDR_W-1:0] cla_q;
    logic [CNT_W-1:0]  redir_q;
    logic              flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cla_q   <= '0;
            redir_q <= '0;
            flag_q  <= 1'b0;
        end else begin
            flag_q <= loop_hit_i;
            if (loop_hit_i) begin
                cla_q   <= loop_end_i;
                redir_q <= unreq_nxt_i;
            end else if (grant_i && (redir_q != '0)) begin
                redir_q <= redir_q - len_i;
            end
        end
    end

    // Redirected frames come from just before the latched loop end
    assign fetch_addr_o = (redir_q != '0) ? (cla_q - ADDR_W'(redir_q))
                                          : (cur_addr_i - ADDR_W'(unreq_i));
    assign redir_o      = redir_q;
    assign loop_flag_o  = flag_q;

    // R7: the loop flag follows a crossing by one cycle
    p_flag_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        loop_hit_i |=> loop_flag_o);

    // R8: a redirected grant never asks beyond the redirect count
    p_redir_len_r8: assert property (@(posedge clk) disable iff (rst)
        grant_i && (redir_q != '0) |-> len_i <= redir_q);

    // R8: the redirect count never exceeds the ring size
    p_redir_bound_r8: assert property (@(posedge clk) disable iff (rst)
        redir_q <= CNT_W'(DEPTH));

endmodule

// File: rtl/vsc_cache_ctrl.sv
module vsc_cache_ctrl #(
    parameter int ADDR_W      = 24,
    parameter int FRAME_W     = 32,
    parameter int DEPTH       = 64,
    parameter int FETCH_BYTES = 32,
    localparam int IDX_W      = $clog2(DEPTH),
    localparam int CNT_W      = IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         fmt_i,
    input  logic [ADDR_W-1:0]  loop_start_i,
    input  logic [ADDR_W-1:0]  loop_end_i,
    input  logic               consume_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic               frame_ok_o,
    output logic [ADDR_W-1:0]  cur_addr_o,
    output logic [CNT_W-1:0]   inv_cnt_o,
    output logic               loop_flag_o,
    output logic               fetch_req_o,
    output logic [ADDR_W-1:0]  fetch_addr_o,
    output logic [CNT_W-1:0]   fetch_len_o,
    input  logic               fetch_gnt_i,
    input  logic               fill_valid_i,
    input  logic [FRAME_W-1:0] fill_data_i
);
    import vsc_pkg::*;

    logic [CNT_W-1:0]  thr;
    logic [IDX_W-1:0]  rd_ptr;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  inv_cnt, inv_nxt;
    logic [CNT_W-1:0]  pend, pend_nxt;
    logic [CNT_W-1:0]  unreq, unreq_nxt;
    logic [CNT_W-1:0]  redir, len;
    logic              consume_ok, loop_hit;
    logic              grant, fill_we;
    logic [IDX_W-1:0]  waddr;

    assign thr       = CNT_W'(burst_frames(fmt_i, FETCH_BYTES));
    assign unreq     = inv_cnt - pend;
    assign unreq_nxt = inv_nxt - pend_nxt;

    vsc_pointers #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_ptrs (
        .clk          (clk),
        .rst          (rst),
        .consume_i    (consume_i),
        .fill_we_i    (fill_we),
        .loop_start_i (loop_start_i),
        .loop_end_i   (loop_end_i),
        .rd_ptr_o     (rd_ptr),
        .cur_addr_o   (cur_addr),
        .inv_cnt_o    (inv_cnt),
        .inv_nxt_o    (inv_nxt),
        .consume_ok_o (consume_ok),
        .loop_hit_o   (loop_hit)
    );

    vsc_refill_fsm #(.DEPTH(DEPTH)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .thr_i        (thr),
        .unreq_i      (unreq),
        .redir_i      (redir),
        .rd_ptr_i     (rd_ptr),
        .gnt_i        (fetch_gnt_i),
        .fill_valid_i (fill_valid_i),
        .req_o        (fetch_req_o),
        .grant_o      (grant),
        .len_o        (len),
        .pend_o       (pend),
        .pend_nxt_o   (pend_nxt),
        .we_o         (fill_we),
        .waddr_o      (waddr)
    );

    vsc_loop_tracker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_loop (
        .clk          (clk),
        .rst          (rst),
        .loop_hit_i   (loop_hit),
        .loop_end_i   (loop_end_i),
        .cur_addr_i   (cur_addr),
        .unreq_i      (unreq),
        .unreq_nxt_i  (unreq_nxt),
        .grant_i      (grant),
        .len_i        (len),
        .redir_o      (redir),
        .fetch_addr_o (fetch_addr_o),
        .loop_flag_o  (loop_flag_o)
    );

    vsc_frame_store #(.FRAME_W(FRAME_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .we_i    (fill_we),
        .waddr_i (waddr),
        .wdata_i (fill_data_i),
        .raddr_i (rd_ptr),
        .rdata_o (frame_o)
    );

    assign frame_ok_o  = (inv_cnt != CNT_W'(DEPTH));
    assign cur_addr_o  = cur_addr;
    assign inv_cnt_o   = inv_cnt;
    assign fetch_len_o = len;

    // R9: a consume is only accepted when the output frame is valid
    p_consume_valid_r9: assert property (@(posedge clk) disable iff (rst)
        consume_ok |-> frame_ok_o);

    // R5: owed frames never exceed the empty slots
    p_owed_fit_r5: assert property (@(posedge clk) disable iff (rst)
        pend <= inv_cnt);

endmodule

// File: tb/test_vsc_cache_ctrl.sv
module test_vsc_cache_ctrl;

    localparam int ADDR_W      = 24;
    localparam int FRAME_W     = 32;
    localparam int DEPTH       = 64;
    localparam int FETCH_BYTES = 32;
    localparam int CNT_W       = 7;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [1:0]         fmt = 2'b00;
    logic [ADDR_W-1:0]  lstart = '0, lend = '0;
    logic               consume = 1'b0, gnt = 1'b0, fv = 1'b0;
    logic [FRAME_W-1:0] fdata = '0;
    logic [FRAME_W-1:0] frame_o;
    logic               frame_ok_o, loop_flag_o, fetch_req_o;
    logic [ADDR_W-1:0]  cur_addr_o, fetch_addr_o;
    logic [CNT_W-1:0]   inv_cnt_o, fetch_len_o;

    always #5 clk = ~clk;

    vsc_cache_ctrl #(.ADDR_W(ADDR_W), .FRAME_W(FRAME_W), .DEPTH(DEPTH),
                     .FETCH_BYTES(FETCH_BYTES)) i_vsc_cache_ctrl (
        .clk(clk), .rst(rst), .fmt_i(fmt), .loop_start_i(lstart), .loop_end_i(lend),
        .consume_i(consume), .frame_o(frame_o), .frame_ok_o(frame_ok_o),
        .cur_addr_o(cur_addr_o), .inv_cnt_o(inv_cnt_o), .loop_flag_o(loop_flag_o),
        .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o), .fetch_len_o(fetch_len_o),
        .fetch_gnt_i(gnt), .fill_valid_i(fv), .fill_data_i(fdata)
    );

    int total = 0, bad = 0;
    bit done = 1'b0;

    // Bench reference state
    logic [ADDR_W-1:0] m_ca, m_cla, fill_next;
    logic [ADDR_W-1:0] hist [DEPTH];
    int m_inv, m_owed, m_r, head, idle_cnt;
    bit m_flag, prev_both;

    function automatic logic [FRAME_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
        return {a[7:0] ^ 8'h3C, a};
    endfunction

    function automatic int thr_of(input logic [1:0] f);
        return FETCH_BYTES >> (int'(f[1]) + int'(f[0]));
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; consume = 1'b0; gnt = 1'b0; fv = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_ca = '0; m_cla = '0; fill_next = '0;
        m_inv = DEPTH; m_owed = 0; m_r = 0; head = 0; idle_cnt = 0;
        m_flag = 1'b0; prev_both = 1'b0;
        for (int j = 0; j < DEPTH; j++) hist[j] = ADDR_W'(j - DEPTH);
        // R1: reset state
        chk(inv_cnt_o == CNT_W'(DEPTH), "R1 invalid count", inv_cnt_o, DEPTH);
        chk(cur_addr_o == '0, "R1 current address", cur_addr_o, 0);
        chk(!fetch_req_o, "R1 no request", fetch_req_o, 0);
        chk(!loop_flag_o, "R1 loop flag", loop_flag_o, 0);
        chk(!frame_ok_o, "R1 frame ok", frame_ok_o, 0);
    endtask

    // One cycle: check at negedge, drive, update model, advance to next negedge
    task automatic step(input int pc, input int pg, input int pf);
        int t, u, exp_len, inv_n, owed_n;
        bit acc, gf, we, hit;
        logic [ADDR_W-1:0] exp_addr;
        t = thr_of(fmt);
        u = m_inv - m_owed;
        chk(cur_addr_o == m_ca, "R2 current address", cur_addr_o, m_ca);
        chk(inv_cnt_o == CNT_W'(m_inv), prev_both ? "R10 invalid count" : "R5 invalid count",
            inv_cnt_o, m_inv);
        chk(loop_flag_o == m_flag, "R7 loop flag", loop_flag_o, m_flag);
        chk(frame_ok_o == (m_inv != DEPTH), "R9 frame ok", frame_ok_o, (m_inv != DEPTH));
        if (fetch_req_o) chk(u >= t, "R3 request room", u, t);
        if (!fetch_req_o && m_owed == 0 && u >= t) idle_cnt++; else idle_cnt = 0;
        if (idle_cnt >= 3) chk(1'b0, "R6 request missing", 0, 1);

        consume = (($urandom % 100) < pc);
        gnt     = (($urandom % 100) < pg);
        fv      = (($urandom % 100) < pf);
        fdata   = (m_owed != 0) ? mem_word(fill_next) : FRAME_W'($urandom);

        acc = consume && (m_inv != DEPTH);
        gf  = fetch_req_o && gnt;
        we  = fv && (m_owed != 0);
        exp_len  = (m_r != 0) ? ((m_r < t) ? m_r : t) : t;
        exp_addr = (m_r != 0) ? (m_cla - ADDR_W'(m_r)) : (m_ca - ADDR_W'(u));
        if (gf) begin
            chk(fetch_len_o == CNT_W'(exp_len), (m_r != 0) ? "R8 redirect length" : "R3 burst length",
                fetch_len_o, exp_len);
            chk(fetch_addr_o == exp_addr, (m_r != 0) ? "R8 redirect address" : "R4 linear address",
                fetch_addr_o, exp_addr);
        end
        if (acc) begin
            chk(frame_o == mem_word(hist[head]), "R9 frame at read pointer", frame_o, mem_word(hist[head]));
            hist[head] = m_ca;
            head = (head + 1) % DEPTH;
        end
        if (we) fill_next = fill_next + ADDR_W'(1);
        if (gf) fill_next = exp_addr;

        inv_n  = m_inv + int'(acc) - int'(we);
        owed_n = gf ? exp_len : m_owed - int'(we);
        hit    = acc && ((m_ca + ADDR_W'(1)) == lend);
        if (acc) m_ca = hit ? lstart : m_ca + ADDR_W'(1);
        if (hit) begin
            m_r = inv_n - owed_n;
            m_cla = lend;
        end else if (gf && m_r != 0) begin
            m_r = m_r - exp_len;
        end
        m_flag = hit;
        prev_both = acc && we;
        m_inv = inv_n;
        m_owed = owed_n;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        int seed;
        seed = int'($urandom(32'h5EED_0042));
        for (int f = 0; f < 4; f++) begin
            fmt = 2'(f);
            lstart = ADDR_W'(128 + ($urandom % 64));
            lend   = lstart + ADDR_W'(140 + ($urandom % 120));
            do_reset();
            // R2 and R5: consume and stray fill on an empty ring do nothing
            repeat (3) step(100, 0, 100);
            chk(cur_addr_o == '0, "R2 consume ignored while empty", cur_addr_o, 0);
            chk(inv_cnt_o == CNT_W'(DEPTH), "R5 stray fill ignored", inv_cnt_o, DEPTH);
            // R6: request held while not granted
            repeat (4) step(0, 0, 0);
            chk(fetch_req_o, "R6 request held", fetch_req_o, 1);
            // Random traffic over several loop periods
            repeat (5000) step(55, 60, 80);
            repeat (1500) step(90, 25, 45);
            repeat (1500) step(30, 90, 95);
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule